// File: doc/BRIEF.md
# Host Buffer-Exchange Interrupt Controller

This block lets a host processor service two buffer-exchange events through a small register window. One event means a transmit buffer needs the host. The other means a receive buffer is ready for the host. Each event sets a pending bit in a read-only status register. The bit is set whatever the enable settings are.

An 8-bit enable register holds two things:
- a separate enable bit for each event;
- one master enable bit that gates both events.

The interrupt pin is active low and level sensitive. It stays low while an enabled event is pending and the master enable is set. The host clears a pending bit by writing zero to the clear address for that event. Neither clear address can be read back.

The block does not track whether the host acknowledged an interrupt. A later event simply sets its pending bit again.

Top module: `hostirq_ctrl`

## Requirements
- R1: After a synchronous reset:
  - the enable register and both pending bits are zero;
  - `irq_n` is high;
  - `bus_rdata` is zero.
- R2: The enable register at address 0x4F is 8 bits wide, readable and writable. Bit 2 enables the transmit event, bit 3 enables the receive event and bit 7 is the master enable. Every written bit reads back unchanged.
- R3: The status register is at address 0x50.
  - A `tx_evt` pulse sets bit 2.
  - An `rx_evt` pulse sets bit 3.
  - Each bit is set whatever the enable register holds.
  - All other bits of the status register read as zero.
- R4: Clearing works as follows.
  - Writing 0x00 to address 0x42 clears status bit 2.
  - Writing 0x00 to address 0x43 clears status bit 3.
  - A non-zero value written to either address changes nothing.
- R5: An event and a zero write to its clear address can fall in the same cycle. The event wins and the status bit stays set.
- R6: `irq_n` is registered. It goes low one cycle after a cycle in which enable bit 7 is set and at least one of these holds:
  - status bit 2 and enable bit 2 are both set;
  - status bit 3 and enable bit 3 are both set.

  Otherwise it is high one cycle later.
- R7: `bus_rdata` is registered. It shows the addressed register one cycle after a cycle in which `bus_re` is high. It holds the value from before any write in that same cycle. It is zero when `bus_re` was low, and zero for the clear addresses and for unmapped addresses.
- R8: Writes to the status register at address 0x50 have no effect.
- R9: A new event on a bit that is already pending leaves it set. An event after a clear sets the bit again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| tx_evt | input | 1 | Transmit-buffer event pulse |
| rx_evt | input | 1 | Receive-buffer event pulse |
| irq_n | output | 1 | Active-low level interrupt |

## Verification
An event and a host clear of the same status bit can arrive in the same cycle. The bench provokes this by driving `tx_evt` high in the same cycle as a 0x00 write to 0x42. It then reads back 0x50 and expects bit 2 still set.

A second overlap is a read and a write of the enable register in the same cycle. The bench issues both strobes together at 0x4F and expects the old enable value on `bus_rdata`. A later read must return the new value.

A behavioural model checks `irq_n` and `bus_rdata` on every clock throughout.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
  localparam int NSRC     = 2;
  localparam int ADDR_CLR0 = 'h42;
  localparam int ADDR_EN   = 'h4F;
  localparam int ADDR_STAT = 'h50;
  localparam int MASTER_BIT = 7;
  localparam int FIRST_SRC_BIT = 2;

  function automatic int src_bit(input int idx);
    return FIRST_SRC_BIT + idx;
  endfunction

  function automatic int clr_addr(input int idx);
    return ADDR_CLR0 + idx;
  endfunction
endpackage

// File: rtl/hirq_src_cell.sv
module hirq_src_cell (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clr,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst)      pend <= 1'b0;
    else if (evt) pend <= 1'b1;
    else if (clr) pend <= 1'b0;
  end
endmodule

// File: rtl/hirq_en_reg.sv
module hirq_en_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst)         en_q <= '0;
    else if (wr_hit) en_q <= wdata;
  end
endmodule

// File: rtl/hirq_rd_port.sv
module hirq_rd_port #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] en_q,
  input  logic [DW-1:0] stat_vec,
  output logic [DW-1:0] rdata
);
  import hirq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || !re) begin
      rdata <= '0;
    end else if (addr == AW'(ADDR_EN)) begin
      rdata <= en_q;
    end else if (addr == AW'(ADDR_STAT)) begin
      rdata <= stat_vec;
    end else begin
      rdata <= '0;
    end
  end
endmodule

// File: rtl/hostirq_ctrl.sv
module hostirq_ctrl #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  input  logic          tx_evt,
  input  logic          rx_evt,
  output logic          irq_n
);
  import hirq_pkg::*;

  logic [NSRC-1:0] evt_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] src_en;
  logic [DW-1:0]   en_q;
  logic [DW-1:0]   stat_vec;
  logic            en_hit;

  assign evt_vec = {rx_evt, tx_evt};
  assign en_hit  = bus_we && (bus_addr == AW'(ADDR_EN));

  hirq_en_reg #(.DW(DW)) u_en (
    .clk(clk), .rst(rst), .wr_hit(en_hit), .wdata(bus_wdata), .en_q(en_q)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign clr_vec[g] = bus_we && (bus_addr == AW'(clr_addr(g))) &&
                        (bus_wdata == '0);
    assign src_en[g]  = en_q[src_bit(g)];
    hirq_src_cell u_cell (
      .clk(clk), .rst(rst), .evt(evt_vec[g]), .clr(clr_vec[g]), .pend(pend[g])
    );
  end

  always_comb begin
    stat_vec = '0;
    for (int i = 0; i < NSRC; i++) stat_vec[src_bit(i)] = pend[i];
  end

  hirq_rd_port #(.AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst(rst), .re(bus_re), .addr(bus_addr),
    .en_q(en_q), .stat_vec(stat_vec), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= !(en_q[MASTER_BIT] && |(pend & src_en));
  end
endmodule

// File: rtl/hirq_ctrl_chk.sv
module hirq_ctrl_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_we,
  input logic          bus_re,
  input logic [DW-1:0] bus_rdata,
  input logic          tx_evt,
  input logic          rx_evt,
  input logic          irq_n,
  input logic [1:0]    pend,
  input logic [DW-1:0] en_q
);
  logic clr_tx;
  logic want_irq;
  assign clr_tx   = bus_we && bus_addr == AW'('h42) && bus_wdata == '0;
  assign want_irq = en_q[7] && ((pend[0] && en_q[2]) || (pend[1] && en_q[3]));

  a_r3_tx_sets: assert property (@(posedge clk) disable iff (rst)
    tx_evt |=> pend[0]);
  a_r3_rx_sets: assert property (@(posedge clk) disable iff (rst)
    rx_evt |=> pend[1]);
  a_r4_tx_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_tx && !tx_evt) |=> !pend[0]);
  a_r5_event_wins: assert property (@(posedge clk) disable iff (rst)
    (clr_tx && tx_evt) |=> pend[0]);
  a_r9_tx_holds: assert property (@(posedge clk) disable iff (rst)
    (!clr_tx && !tx_evt) |=> $stable(pend[0]));
  a_r6_irq_low: assert property (@(posedge clk) disable iff (rst)
    want_irq |=> !irq_n);
  a_r6_irq_high: assert property (@(posedge clk) disable iff (rst)
    !want_irq |=> irq_n);
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> bus_rdata == '0);
endmodule

bind hostirq_ctrl hirq_ctrl_chk u_chk (.*);

// File: tb/hostirq_ctrl_test.sv
module hostirq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic       tx_evt = 1'b0;
  logic       rx_evt = 1'b0;
  logic       irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural reference state
  int m_en = 0, m_s_tx = 0, m_s_rx = 0, m_irq_n = 1, m_rdata = 0;

  always #2 clk = ~clk;

  hostirq_ctrl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .tx_evt(tx_evt), .rx_evt(rx_evt), .irq_n(irq_n)
  );

  function automatic int model_read(input int a);
    if (a == 'h4F) return m_en;
    if (a == 'h50) return (m_s_tx << 2) | (m_s_rx << 3);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_s_tx = 0; m_s_rx = 0; m_irq_n = 1; m_rdata = 0;
    end else begin
      m_rdata = bus_re ? model_read(int'(bus_addr)) : 0;
      m_irq_n = (((m_en >> 7) & 1) == 1 &&
                 ((m_s_tx == 1 && ((m_en >> 2) & 1) == 1) ||
                  (m_s_rx == 1 && ((m_en >> 3) & 1) == 1))) ? 0 : 1;
      if (bus_we && bus_addr == 8'h4F) m_en = int'(bus_wdata);
      if (tx_evt) m_s_tx = 1;
      else if (bus_we && bus_addr == 8'h42 && bus_wdata == 0) m_s_tx = 0;
      if (rx_evt) m_s_rx = 1;
      else if (bus_we && bus_addr == 8'h43 && bus_wdata == 0) m_s_rx = 0;
    end
  end

  // every-clock comparison against the model (R6, R7)
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (int'(irq_n) != m_irq_n) begin
        fails++;
        $display("FAIL R6 irq_n act=%0d exp=%0d t=%0t", irq_n, m_irq_n, $time);
      end
      checks++;
      if (int'(bus_rdata) != m_rdata) begin
        fails++;
        $display("FAIL R7 rdata act=%0h exp=%0h t=%0t", bus_rdata, m_rdata, $time);
      end
    end
  end

  task automatic cyc(input bit we, input bit re, input int a, input int d,
                     input bit tx, input bit rx);
    @(negedge clk);
    bus_we = we; bus_re = re; bus_addr = 8'(a); bus_wdata = 8'(d);
    tx_evt = tx; rx_evt = rx;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic expect_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    cyc(0, 1, a, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    expect_val(tag, int'(bus_rdata), exp);
  endtask

  task automatic wr(input int a, input int d);
    cyc(1, 0, a, d, 0, 0);
    idle(1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    expect_val("R1 irq_n", int'(irq_n), 1);
    expect_val("R1 rdata", int'(bus_rdata), 0);
    rd('h50, 'h00, "R1 status");
    rd('h4F, 'h00, "R1 enable");
    // R2 enable register read/write
    wr('h4F, 'hA5);
    rd('h4F, 'hA5, "R2 readback");
    wr('h4F, 'h00);
    // R3 events latch with everything disabled
    cyc(0, 0, 0, 0, 1, 0); idle(1);
    rd('h50, 'h04, "R3 tx bit");
    expect_val("R3 irq masked", int'(irq_n), 1);
    cyc(0, 0, 0, 0, 0, 1); idle(1);
    rd('h50, 'h0C, "R3 rx bit");
    // R8 status write ignored
    wr('h50, 'h00);
    rd('h50, 'h0C, "R8 status write");
    // R4 clear semantics
    wr('h42, 'h11);
    rd('h50, 'h0C, "R4 nonzero no clear");
    wr('h42, 'h00);
    rd('h50, 'h08, "R4 clear tx");
    wr('h43, 'h00);
    rd('h50, 'h00, "R4 clear rx");
    // R6 gating
    cyc(0, 0, 0, 0, 1, 0);
    wr('h4F, 'h04); idle(1);
    expect_val("R6 no master", int'(irq_n), 1);
    wr('h4F, 'h84); idle(1);
    expect_val("R6 asserted", int'(irq_n), 0);
    wr('h4F, 'h88); idle(1);
    expect_val("R6 wrong enable", int'(irq_n), 1);
    cyc(0, 0, 0, 0, 0, 1); idle(2);
    expect_val("R6 rx asserted", int'(irq_n), 0);
    wr('h43, 'h00); idle(1);
    expect_val("R6 released", int'(irq_n), 1);
    wr('h42, 'h00);
    // R5 event wins over clear
    cyc(1, 0, 'h42, 'h00, 1, 0); idle(1);
    rd('h50, 'h04, "R5 event wins");
    // R9 re-set without acknowledge
    cyc(0, 0, 0, 0, 1, 0); idle(1);
    rd('h50, 'h04, "R9 repeat event");
    wr('h42, 'h00);
    rd('h50, 'h00, "R9 cleared");
    cyc(0, 0, 0, 0, 1, 0); idle(1);
    rd('h50, 'h04, "R9 re-set");
    // R7 read details
    rd('h42, 'h00, "R7 clear addr tx");
    rd('h43, 'h00, "R7 clear addr rx");
    rd('h10, 'h00, "R7 unmapped");
    cyc(1, 1, 'h4F, 'h33, 0, 0); idle(1);
    expect_val("R7 read before write", int'(bus_rdata), 'h88);
    rd('h4F, 'h33, "R7 new value");
    idle(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule